// File: doc/BRIEF.md
# Multimode Serial Port Controller

This block is a full-duplex serial port that software drives through a byte-wide register window. One address holds a control and status byte: the mode, the filter enable, the receive enable, the ninth transmit and receive bits, and the two completion flags. The other address is shared. A write to it loads the transmit shift register and starts a frame. A read from it returns a receive holding register that is physically separate from the transmit side. The port has four modes. Mode 0 is a synchronous shifter: the RXD pin carries data and TXD carries the shift clock. Mode 1 is an 8-bit asynchronous link. Modes 2 and 3 are 9-bit asynchronous links, and their ninth bit can be used to filter multiprocessor addresses.

Bit timing comes from three tick enables supplied outside the block. Two are 16x oversample ticks: the fixed one is used in mode 2, and the variable one in modes 1 and 3. The third tick clocks the mode 0 shifter. The receiver holds one complete byte in its holding register while the next frame is still shifting in. A frame is delivered only if the receive-done flag was clear when the frame finished and the filter rule accepts it. The register window applies no back-pressure, and every write takes effect in the cycle it is presented. If software writes the data address while a frame is still going out, the transmitter restarts with the new byte. Software must watch the transmit-done flag to avoid this.

Top module: `sp_port`

## Requirements
- R1: After reset the control byte reads 0x00, the receive holding register reads 0x00, `txd_o` is 1 and `rxd_oe` is 0.
- R2: With `reg_addr`=0 the window reads and writes the control byte, laid out MSB to LSB as mode[1], mode[0], SM2, REN, TB8, RB8, TI, RI. With `reg_addr`=1 a write starts a transmission, and a read returns the receive holding register, never the byte that was written.
- R3: In modes 1 to 3 a transmit frame on `txd_o` is a 0 start bit, then 8 data bits LSB first, then the ninth bit in modes 2 and 3, then a 1 stop bit. Each bit lasts 16 ticks, taken from `tick_fix` in mode 2 and from `tick_var` in modes 1 and 3.
- R4: TB8 is sent as the ninth bit in modes 2 and 3. In mode 1 TB8 is ignored, and the stop bit directly follows the 8th data bit.
- R5: TI becomes 1 one clock after the stop bit starts on the line. In mode 0 it becomes 1 one clock after the 8th rising shift clock. Hardware never clears TI or RI; only a control write clears them.
- R6: An accepted asynchronous frame loads the holding register, sets RI and writes RB8. RB8 takes the ninth bit in modes 2 and 3 and the stop bit in mode 1. The receiver takes each bit as the majority of three samples around the middle of the bit.
- R7: In mode 1 with SM2=1, a frame whose stop bit is 0 is dropped: RI, RB8 and the holding register are left unchanged. With SM2=0 the frame is kept whatever the stop bit is.
- R8: In modes 2 and 3 with SM2=1, a frame whose ninth bit is 0 is dropped. With SM2=0 every frame is kept.
- R9: A frame that completes while RI=1 is dropped, and the holding register keeps its earlier byte.
- R10: The next frame can shift in while the previous byte waits in the holding register. If RI is cleared before the next frame ends, that frame is delivered.
- R11: With REN=0 no reception starts. In mode 0 a reception starts only while REN=1 and RI=0; until then TXD carries no shift clock.
- R12: A mode 0 transmit drives `rxd_oe`=1 for the whole transfer. It puts the 8 data bits on `rxd_o` LSB first, changing them only while the clock on `txd_o` is low, and each bit is valid at the rising edge of the clock.
- R13: A mode 0 receive outputs the shift clock on `txd_o` and samples `rxd_i` at each rising edge, LSB first. SM2 has no effect in mode 0, and RB8 is left unchanged.
- R14: Transmission and reception run at the same time in the asynchronous modes, and neither corrupts the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control byte, 1 selects the data address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected address, combinational |
| tick_var | input | 1 | 16x oversample tick used in modes 1 and 3 |
| tick_fix | input | 1 | 16x oversample tick used in mode 2 |
| tick_shift | input | 1 | Mode 0 shifter tick; each bit takes two ticks |
| rxd_i | input | 1 | Serial input |
| rxd_o | output | 1 | Mode 0 transmit data |
| rxd_oe | output | 1 | Output enable for `rxd_o` |
| txd_o | output | 1 | Asynchronous serial output, or the mode 0 shift clock |

## Verification
A data write changes `txd_o` at the next clock edge, after which each bit lasts exactly 16 ticks. The bench therefore waits for the start edge and samples every bit half a bit period after it begins, so tick phase jitter stays well inside the bit. TI and RI are set one clock after the event that causes them, and the holding register loads on that same edge. The flags are checked at the middle of the stop bit, or a few clocks after a received frame ends, and never on the edge itself. In mode 0 the bench follows the clock on `txd_o`. It reads `rxd_o` at each rising edge. It drives `rxd_i` right after each falling edge, which leaves the two-stage input synchronizer enough cycles before the rising-edge sample.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'd0,
    MODE_UART8  = 2'd1,
    MODE_UART9F = 2'd2,
    MODE_UART9V = 2'd3
  } sp_mode_e;

  // control byte bit positions (software visible layout)
  localparam int unsigned CB_RI   = 0;
  localparam int unsigned CB_TI   = 1;
  localparam int unsigned CB_RB8  = 2;
  localparam int unsigned CB_TB8  = 3;
  localparam int unsigned CB_REN  = 4;
  localparam int unsigned CB_SM2  = 5;
  localparam int unsigned CB_MODE = 6;

  localparam int unsigned FRAME_MAX = 11;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= '1;
        else        pipe <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sp_tx.sv
module sp_tx import sp_pkg::*; #(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  sp_mode_e   mode,
  input  logic       load,
  input  logic [7:0] din,
  input  logic       tb8,
  input  logic       tick_a,
  input  logic       tick_s,
  output logic       txd,
  output logic       m0_busy,
  output logic       m0_dat,
  output logic       ti_set
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned IW = $clog2(FRAME_MAX);
  localparam logic [CW-1:0] CNT_END = CW'(OVS - 1);

  logic                 busy_a, busy_s, line, sclk, phase;
  logic [FRAME_MAX-1:0] frame;
  logic [IW-1:0]        idx, last;
  logic [CW-1:0]        cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_a <= 1'b0; busy_s <= 1'b0; line <= 1'b1; sclk <= 1'b1;
      phase  <= 1'b0; frame  <= '1;   idx  <= '0;   last <= '0;
      cnt    <= '0;   m0_dat <= 1'b1; ti_set <= 1'b0;
    end else begin
      ti_set <= 1'b0;
      if (load) begin
        idx <= '0;
        cnt <= '0;
        if (mode == MODE_SHIFT) begin
          busy_s <= 1'b1; busy_a <= 1'b0; line <= 1'b1;
          sclk   <= 1'b1; phase  <= 1'b0;
          frame  <= {3'b111, din};
          m0_dat <= din[0];
        end else begin
          busy_a <= 1'b1; busy_s <= 1'b0; line <= 1'b0;
          if (mode == MODE_UART8) begin
            frame <= {2'b11, din, 1'b0};
            last  <= IW'(9);
          end else begin
            frame <= {1'b1, tb8, din, 1'b0};
            last  <= IW'(10);
          end
        end
      end else if (busy_a && tick_a) begin
        if (cnt == CNT_END) begin
          cnt <= '0;
          if (idx == last) begin
            busy_a <= 1'b0;
          end else begin
            idx  <= idx + 1'b1;
            line <= frame[idx + 1'b1];
            if (idx + 1'b1 == last) ti_set <= 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (busy_s && tick_s) begin
        if (!phase) begin
          sclk   <= 1'b0;
          m0_dat <= frame[idx];
          phase  <= 1'b1;
        end else begin
          sclk  <= 1'b1;
          phase <= 1'b0;
          if (idx == IW'(7)) begin
            busy_s <= 1'b0;
            ti_set <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  assign txd     = busy_s ? sclk : line;
  assign m0_busy = busy_s;
endmodule

// File: rtl/sp_rx.sv
module sp_rx import sp_pkg::*; #(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  sp_mode_e   mode,
  input  logic       sm2,
  input  logic       ren,
  input  logic       ri,
  input  logic       tick_a,
  input  logic       tick_s,
  input  logic       tx_m0_busy,
  input  logic       rxd,
  output logic       set_o,
  output logic [7:0] data_o,
  output logic       rb8_o,
  output logic       rb8_we_o,
  output logic       m0_busy_o,
  output logic       sclk_o
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned IW = $clog2(FRAME_MAX);
  localparam logic [CW-1:0] SMP0    = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] SMP1    = CW'(OVS/2);
  localparam logic [CW-1:0] SMP2    = CW'(OVS/2 + 1);
  localparam logic [CW-1:0] CNT_END = CW'(OVS - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_ASYNC, RX_SHIFT} rx_st_e;

  rx_st_e        st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [7:0]    sh;
  logic          s1, s2, ninth, phase, maj, nine_bit, at_stop, keep;

  assign maj      = (s1 & s2) | (s1 & rxd) | (s2 & rxd);
  assign nine_bit = (mode != MODE_UART8);
  assign at_stop  = nine_bit ? (idx == IW'(10)) : (idx == IW'(9));
  // filter: in 8-bit mode the stop bit qualifies, in 9-bit modes the ninth bit
  assign keep     = !ri && (!sm2 || (nine_bit ? ninth : maj));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE; cnt <= '0; idx <= '0; sh <= '0; s1 <= 1'b1; s2 <= 1'b1;
      ninth <= 1'b0; phase <= 1'b0; sclk_o <= 1'b1;
      set_o <= 1'b0; data_o <= '0; rb8_o <= 1'b0; rb8_we_o <= 1'b0;
    end else begin
      set_o    <= 1'b0;
      rb8_we_o <= 1'b0;
      unique case (st)
        RX_IDLE: begin
          sclk_o <= 1'b1;
          idx    <= '0;
          cnt    <= '0;
          phase  <= 1'b0;
          if (mode == MODE_SHIFT) begin
            if (ren && !ri && !set_o && !tx_m0_busy) st <= RX_SHIFT;
          end else if (ren && tick_a && !rxd) begin
            st <= RX_ASYNC;
          end
        end
        RX_ASYNC: if (tick_a) begin
          cnt <= (cnt == CNT_END) ? '0 : cnt + 1'b1;
          if (cnt == CNT_END) idx <= idx + 1'b1;
          if (cnt == SMP0) s1 <= rxd;
          if (cnt == SMP1) s2 <= rxd;
          if (cnt == SMP2) begin
            if (idx == '0) begin
              if (maj) st <= RX_IDLE;           // false start
            end else if (idx <= IW'(8)) begin
              sh <= {maj, sh[7:1]};
            end else if (at_stop) begin
              st <= RX_IDLE;
              if (keep) begin
                set_o    <= 1'b1;
                data_o   <= sh;
                rb8_o    <= nine_bit ? ninth : maj;
                rb8_we_o <= 1'b1;
              end
            end else begin
              ninth <= maj;
            end
          end
        end
        RX_SHIFT: if (tick_s) begin
          if (!phase) begin
            sclk_o <= 1'b0;
            phase  <= 1'b1;
          end else begin
            sclk_o <= 1'b1;
            phase  <= 1'b0;
            sh     <= {rxd, sh[7:1]};
            if (idx == IW'(7)) begin
              st     <= RX_IDLE;
              set_o  <= 1'b1;
              data_o <= {rxd, sh[7:1]};
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  assign m0_busy_o = (st == RX_SHIFT);
endmodule

// File: rtl/sp_port.sv
module sp_port import sp_pkg::*; #(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tick_var,
  input  logic       tick_fix,
  input  logic       tick_shift,
  input  logic       rxd_i,
  output logic       rxd_o,
  output logic       rxd_oe,
  output logic       txd_o
);
  logic [7:0] ctrl_q, rbuf_q, rx_data;
  logic       wr_ctrl, wr_data, tick_a, rxd_s;
  logic       tx_txd, tx_m0_busy, ti_set;
  logic       rx_set, rx_rb8, rx_rb8_we, rx_m0_busy, rx_sclk;
  sp_mode_e   mode;

  assign wr_ctrl = reg_we && !reg_addr;
  assign wr_data = reg_we &&  reg_addr;
  assign mode    = sp_mode_e'(ctrl_q[CB_MODE +: 2]);
  assign tick_a  = (mode == MODE_UART9F) ? tick_fix : tick_var;

  sp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd_i), .q(rxd_s)
  );

  sp_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .load(wr_data), .din(reg_wdata),
    .tb8(ctrl_q[CB_TB8]), .tick_a(tick_a), .tick_s(tick_shift),
    .txd(tx_txd), .m0_busy(tx_m0_busy), .m0_dat(rxd_o), .ti_set(ti_set)
  );

  sp_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sm2(ctrl_q[CB_SM2]),
    .ren(ctrl_q[CB_REN]), .ri(ctrl_q[CB_RI]), .tick_a(tick_a),
    .tick_s(tick_shift), .tx_m0_busy(tx_m0_busy), .rxd(rxd_s),
    .set_o(rx_set), .data_o(rx_data), .rb8_o(rx_rb8), .rb8_we_o(rx_rb8_we),
    .m0_busy_o(rx_m0_busy), .sclk_o(rx_sclk)
  );

  // hardware flag sets take priority over a software write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rbuf_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata;
      if (ti_set)  ctrl_q[CB_TI] <= 1'b1;
      if (rx_set) begin
        ctrl_q[CB_RI] <= 1'b1;
        rbuf_q        <= rx_data;
        if (rx_rb8_we) ctrl_q[CB_RB8] <= rx_rb8;
      end
    end
  end

  assign reg_rdata = reg_addr ? rbuf_q : ctrl_q;
  assign rxd_oe    = tx_m0_busy;
  assign txd_o     = (rx_m0_busy && !tx_m0_busy) ? rx_sclk : tx_txd;
endmodule

// File: rtl/sp_port_chk.sv
module sp_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctrl,
  input logic [7:0] rbuf,
  input logic       wr_ctrl,
  input logic       txd_o,
  input logic       rxd_oe
);
  // R5: TI appears while the line is high (stop bit, or idle-high shift clock)
  p_ti_on_high_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl[1]) && !$past(wr_ctrl)) |-> txd_o);

  // R5: completion flags are never cleared without a control write
  p_flags_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_ctrl) |-> ((ctrl[1:0] & $past(ctrl[1:0])) == $past(ctrl[1:0])));

  // R9: the holding register changes only together with a fresh RI
  p_buf_with_ri_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rbuf) |-> $rose(ctrl[0]));

  // R7 and R8: with SM2 set in an asynchronous mode, a delivered frame has RB8=1
  p_filter_rb8_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl[0]) && !$past(wr_ctrl) && (ctrl[7:6] != 2'b00) && ctrl[5])
      |-> ctrl[2]);

  // R12: the data pin is driven only by a mode 0 transfer
  p_oe_shift_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxd_oe) |-> (ctrl[7:6] == 2'b00));
endmodule

bind sp_port sp_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl_q), .rbuf(rbuf_q),
  .wr_ctrl(wr_ctrl), .txd_o(txd_o), .rxd_oe(rxd_oe)
);

// File: tb/sim_sp_port.sv
module sim_sp_port;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       reg_we = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       tick_var = 1'b0, tick_fix = 1'b0, tick_shift = 1'b0;
  logic       rxd_i = 1'b1, rxd_o, rxd_oe, txd_o;
  int         n_chk = 0, n_bad = 0;
  logic [7:0] prev = 8'h00;

  sp_port u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_var(tick_var),
    .tick_fix(tick_fix), .tick_shift(tick_shift), .rxd_i(rxd_i),
    .rxd_o(rxd_o), .rxd_oe(rxd_oe), .txd_o(txd_o)
  );

  initial forever #2 clk = ~clk;

  // tick enables: variable every 4 clocks, fixed every 2, shift every 4
  initial begin
    int cv = 0, cf = 0, cs = 0;
    forever begin
      @(negedge clk);
      cv = (cv + 1) % 4; cf = (cf + 1) % 2; cs = (cs + 1) % 4;
      tick_var = (cv == 0); tick_fix = (cf == 0); tick_shift = (cs == 2);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata; reg_addr = 1'b0;
  endtask

  task automatic wait_line(input logic val, input string req);
    int n = 0;
    while (txd_o !== val && n < 4000) begin @(negedge clk); n++; end
    if (n >= 4000) chk(req, 32'(txd_o), 32'(val));
  endtask

  task automatic cap_tx(input int bp, input int nb,
                        output logic [10:0] bits, output logic [10:0] tis);
    bits = '1; tis = '0;
    wait_line(1'b0, "R3 start edge");
    cyc(bp / 2);
    for (int i = 0; i < nb; i++) begin
      bits[i] = txd_o; tis[i] = reg_rdata[1];
      cyc(bp);
    end
  endtask

  task automatic rx_send(input logic [10:0] b, input int nb, input int bp);
    for (int i = 0; i < nb; i++) begin rxd_i = b[i]; cyc(bp); end
    rxd_i = 1'b1;
  endtask

  function automatic logic [10:0] mk_frame(input int m, input logic [7:0] d,
                                           input logic n9, input logic st);
    logic [10:0] f;
    f = {2'b11, d, 1'b0};
    if (m == 1) f[9] = st; else begin f[9] = n9; f[10] = 1'b1; end
    return f;
  endfunction

  function automatic logic f_accept(input int m, input logic s2, input logic ri,
                                    input logic n9, input logic st);
    if (ri) return 1'b0;
    if (m == 1) return !s2 || st;
    return !s2 || n9;
  endfunction

  function automatic logic f_rb8(input int m, input logic n9, input logic st);
    return (m == 1) ? st : n9;
  endfunction

  task automatic rx_case(input int m, input logic s2, input logic [7:0] d,
                         input logic n9, input logic st, input string req);
    logic [7:0] c, v;
    logic acc;
    reg_wr(1'b0, {m[1:0], s2, 1'b1, 4'b0000});
    rx_send(mk_frame(m, d, n9, st), (m == 1) ? 10 : 11, (m == 2) ? 32 : 64);
    cyc(4);
    acc = f_accept(m, s2, 1'b0, n9, st);
    rd(1'b0, c); rd(1'b1, v);
    chk({req, " RI"}, 32'(c[0]), 32'(acc));
    chk({req, " holding register"}, 32'(v), 32'(acc ? d : prev));
    chk({req, " RB8"}, 32'(c[2]), 32'(acc ? f_rb8(m, n9, st) : 1'b0));
    if (acc) prev = d;
  endtask

  initial begin
    logic [7:0]  c, v, d, d2;
    logic [10:0] bits, tis;
    int m, bp, nb;
    logic tb;
    void'($urandom(32'd2024));
    cyc(3); rst_n = 1'b1; cyc(2);

    // R1 reset state
    rd(1'b0, c); chk("R1 control", 32'(c), 32'h00);
    rd(1'b1, v); chk("R1 holding", 32'(v), 32'h00);
    chk("R1 txd", 32'(txd_o), 32'h1);
    chk("R1 oe", 32'(rxd_oe), 32'h0);

    // R2 control readback
    reg_wr(1'b0, 8'hAF); rd(1'b0, c); chk("R2 control readback", 32'(c), 32'hAF);
    reg_wr(1'b0, 8'h00);

    // R3 R4 R5 asynchronous transmit
    for (int k = 0; k < 8; k++) begin
      m  = (k < 3) ? 1 : (k < 6) ? 3 : 2;
      tb = 1'($urandom % 2);
      d  = 8'($urandom);
      bp = (m == 2) ? 32 : 64;
      nb = (m == 1) ? 10 : 11;
      reg_wr(1'b0, {m[1:0], 2'b00, tb, 3'b000});
      reg_wr(1'b1, d);
      if (k == 0) begin
        rd(1'b1, v); chk("R2 data read is holding register", 32'(v), 32'h00);
      end
      cap_tx(bp, nb, bits, tis);
      chk("R3 start bit", 32'(bits[0]), 32'h0);
      chk("R3 data bits", 32'(bits[8:1]), 32'(d));
      if (m == 1) chk("R4 mode 1 ignores TB8", 32'(bits[9]), 32'h1);
      else        chk("R4 ninth bit", 32'(bits[9]), 32'(tb));
      chk("R3 stop bit", 32'(bits[nb-1]), 32'h1);
      chk("R5 TI clear before stop", 32'(tis[nb-2]), 32'h0);
      chk("R5 TI set at stop", 32'(tis[nb-1]), 32'h1);
      cyc(20);
      rd(1'b0, c); chk("R5 TI held", 32'(c[1]), 32'h1);
    end

    // R12 mode 0 transmit
    reg_wr(1'b0, 8'h00);
    d = 8'($urandom);
    reg_wr(1'b1, d);
    chk("R12 oe during transfer", 32'(rxd_oe), 32'h1);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      wait_line(1'b0, "R12 clock low");
      wait_line(1'b1, "R12 clock high");
      v[i] = rxd_o;
    end
    chk("R12 shifted byte", 32'(v), 32'(d));
    cyc(2);
    rd(1'b0, c); chk("R5 TI after mode 0", 32'(c[1]), 32'h1);
    chk("R12 oe released", 32'(rxd_oe), 32'h0);

    // R6 R7 R8 reception, random then directed
    for (int k = 0; k < 8; k++) begin
      m = 1 + int'($urandom % 3);
      rx_case(m, 1'($urandom % 2), 8'($urandom), 1'($urandom % 2),
              (m == 1) ? 1'($urandom % 4 != 0) : 1'b1, "R6 random frame");
    end
    rx_case(1, 1'b1, 8'h3C, 1'b0, 1'b0, "R7 bad stop with SM2");
    rx_case(1, 1'b0, 8'hC3, 1'b0, 1'b0, "R7 bad stop without SM2");
    rx_case(3, 1'b1, 8'h5A, 1'b0, 1'b1, "R8 ninth 0 with SM2");
    rx_case(3, 1'b1, 8'hA5, 1'b1, 1'b1, "R8 ninth 1 with SM2");
    rx_case(2, 1'b0, 8'h96, 1'b0, 1'b1, "R8 ninth 0 without SM2");

    // R9 frame while RI set
    reg_wr(1'b0, 8'h50);
    d = 8'h11; d2 = 8'h22;
    rx_send(mk_frame(1, d, 1'b0, 1'b1), 10, 64);
    rx_send(mk_frame(1, d2, 1'b0, 1'b1), 10, 64);
    cyc(4);
    rd(1'b1, v); chk("R9 old byte kept", 32'(v), 32'(d));
    rd(1'b0, c); chk("R9 RI still set", 32'(c[0]), 32'h1);

    // R10 double buffering
    reg_wr(1'b0, 8'h50);
    d = 8'h4D; d2 = 8'hB2;
    fork
      begin
        rx_send(mk_frame(1, d, 1'b0, 1'b1), 10, 64);
        rx_send(mk_frame(1, d2, 1'b0, 1'b1), 10, 64);
      end
      begin
        logic [7:0] cc, vv;
        int n = 0;
        cc = '0;
        while (!cc[0] && n < 2000) begin rd(1'b0, cc); n++; end
        rd(1'b1, vv); chk("R10 first byte", 32'(vv), 32'(d));
        reg_wr(1'b0, 8'h50);
      end
    join
    cyc(4);
    rd(1'b0, c); chk("R10 second RI", 32'(c[0]), 32'h1);
    rd(1'b1, v); chk("R10 second byte", 32'(v), 32'(d2));
    prev = d2;

    // R11 receive disabled
    reg_wr(1'b0, 8'h40);
    rx_send(mk_frame(1, 8'h77, 1'b0, 1'b1), 10, 64);
    cyc(4);
    rd(1'b0, c); chk("R11 no RI with REN=0", 32'(c[0]), 32'h0);
    rd(1'b1, v); chk("R11 holding unchanged", 32'(v), 32'(prev));

    // R14 full duplex
    reg_wr(1'b0, 8'h50);
    d = 8'($urandom); d2 = 8'($urandom);
    fork
      begin
        reg_wr(1'b1, d);
        cap_tx(64, 10, bits, tis);
      end
      rx_send(mk_frame(1, d2, 1'b0, 1'b1), 10, 64);
    join
    cyc(4);
    chk("R14 tx byte", 32'(bits[8:1]), 32'(d));
    rd(1'b1, v); chk("R14 rx byte", 32'(v), 32'(d2));

    // R11 R13 mode 0 receive
    reg_wr(1'b0, 8'h35);
    cyc(40);
    chk("R11 no shift clock while RI=1", 32'(txd_o), 32'h1);
    d = 8'($urandom);
    reg_wr(1'b0, 8'h34);
    for (int i = 0; i < 8; i++) begin
      wait_line(1'b0, "R13 clock low");
      rxd_i = d[i];
      wait_line(1'b1, "R13 clock high");
    end
    rxd_i = 1'b1;
    cyc(4);
    rd(1'b0, c); rd(1'b1, v);
    chk("R13 RI set with SM2=1", 32'(c[0]), 32'h1);
    chk("R13 received byte", 32'(v), 32'(d));
    chk("R13 RB8 unchanged", 32'(c[2]), 32'h1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule